// File: doc/BRIEF.md
# USB Device Interrupt Status Register

This block holds the pending-interrupt flags of one USB device-side controller in a single 16-bit word. Event sources are pulse inputs from the packet engine and two slow pins from the On-The-Go front end. The pulse inputs are start-of-frame / end-of-packet reception, bus reset detection, and per-endpoint transaction outcomes for endpoints 3 to 7. The two pins are the thresholded VBUS-valid level and the ID pin. Each source has its own enable, and an enabled event latches a sticky flag. Software reads the word at any time and clears pending flags by writing ones. A single interrupt line is raised while any flag is pending.

The two pins are asynchronous. Each passes through a synchronizer and a both-edge detector. The detector stays silent until its history holds a real synchronized sample, so a pin that is already high when reset is released does not raise a flag. An endpoint flag combines several outcomes: ACK sent or received, STALL sent, timeout, IN exception and OUT exception. A NAK also counts, but only while that endpoint's NAK-interrupt enable is set. The parameter `IS_PRIMARY` selects the instance flavour. Only the primary instance has the two pin flags. In the secondary instance those bits read 0.

Top module: `usb_intr_status`

## Requirements
- R1: After reset every status bit reads 0 and `irqOut` is 0.
- R2: In the primary instance, an enabled rising or falling transition of `vbusValid` sets bit 15. The flag is readable three rising clock edges after the first edge that samples the new level.
- R3: In the primary instance, an enabled rising or falling transition of `otgId` sets bit 14, with the same latency as R2.
- R4: In the secondary instance (`IS_PRIMARY`=0), bits 15 and 14 always read 0, whatever the pins do.
- R5: An enabled `sofPulse` sets bit 9 and an enabled `busResetPulse` sets bit 8, visible after the clock edge that samples the pulse.
- R6: For endpoint index e (0..4, endpoint 3+e), any one of `epAck[e]`, `epStall[e]`, `epTimeout[e]`, `epInErr[e]` or `epOutErr[e]` sets bit 3+e when enabled.
- R7: `epNak[e]` sets bit 3+e only while `epNakIntEn[e]` is 1. With the NAK enable at 0 a NAK leaves the bit unchanged.
- R8: A cycle with `wrEn`=1 clears every flag whose `wrData` bit is 1. Bits written with 0 keep their value.
- R9: If a set event and a clearing write hit the same bit in one cycle, the bit ends up set.
- R10: A source whose `irqEn` bit (same position as its status bit) is 0 never sets its flag. A pin transition that happens while disabled is not latched after the enable returns to 1.
- R11: Bits 13 to 10 and 2 to 0 always read 0, even after a write of all ones.
- R12: `irqOut` is 1 exactly when at least one status bit is 1.
- R13: Pins held high across reset release do not produce a flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| vbusValid | input | 1 | Thresholded VBUS level, asynchronous |
| otgId | input | 1 | OTG ID pin level, asynchronous |
| sofPulse | input | 1 | SOF/EOP received, one-cycle pulse |
| busResetPulse | input | 1 | USB bus reset detected, one-cycle pulse |
| epAck | input | NUM_EP | Per endpoint: ACK sent or received |
| epStall | input | NUM_EP | Per endpoint: STALL sent |
| epTimeout | input | NUM_EP | Per endpoint: transaction timeout |
| epInErr | input | NUM_EP | Per endpoint: IN exception error |
| epOutErr | input | NUM_EP | Per endpoint: OUT exception error |
| epNak | input | NUM_EP | Per endpoint: device NAKed the host |
| epNakIntEn | input | NUM_EP | Per endpoint: NAK counts as an event |
| irqEn | input | 16 | Per-flag source enable, bit-aligned with status |
| wrEn | input | 1 | Write strobe for write-one-to-clear |
| wrData | input | 16 | Write data, ones clear flags |
| statusRd | output | 16 | Current status word |
| irqOut | output | 1 | OR of all status bits |

## Verification
The bench builds two instances side by side on the same stimulus. The first uses `IS_PRIMARY`=1, which brings the pin synchronizers, both-edge detection and the startup quieting within reach. The second uses `IS_PRIMARY`=0, which makes the reserved pin bits and their suppression observable. Both use the default five endpoints at base 3, so every endpoint bit, the NAK gating and the set-versus-clear collision are driven on real flag positions.

// File: rtl/usb_intr_pkg.sv
package usb_intr_pkg;

  localparam int REG_W      = 16;
  localparam int VBUS_BIT   = 15;
  localparam int ID_BIT     = 14;
  localparam int SOF_BIT    = 9;
  localparam int BUSRST_BIT = 8;

  // strobes from the control side into the status datapath
  typedef struct packed {
    logic [REG_W-1:0] setMask;
    logic [REG_W-1:0] clrMask;
  } flagStrobe_t;

  // which status bits physically exist for a given instance flavour
  function automatic logic [REG_W-1:0] implMask(input bit isPrimary,
                                                input int epBase,
                                                input int numEp);
    logic [REG_W-1:0] m;
    m = '0;
    m[SOF_BIT]    = 1'b1;
    m[BUSRST_BIT] = 1'b1;
    for (int i = 0; i < numEp; i++) m[epBase+i] = 1'b1;
    if (isPrimary) begin
      m[VBUS_BIT] = 1'b1;
      m[ID_BIT]   = 1'b1;
    end
    return m;
  endfunction

endpackage

// File: rtl/usb_intr_edge.sv
module usb_intr_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic armed,
  input  logic asyncIn,
  output logic edgeSeen
);

  logic [SYNC_STAGES-1:0] syncQ;
  logic                   hist;

  // synchronizer chain plus one history flop; history always tracks,
  // so a transition that was not reported is never reported later
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncQ <= '0;
      hist  <= 1'b0;
    end else begin
      syncQ <= {syncQ[SYNC_STAGES-2:0], asyncIn};
      hist  <= syncQ[SYNC_STAGES-1];
    end
  end

  assign edgeSeen = armed && (hist != syncQ[SYNC_STAGES-1]);

endmodule

// File: rtl/usb_intr_ctrl.sv
module usb_intr_ctrl
  import usb_intr_pkg::*;
#(
  parameter bit IS_PRIMARY  = 1'b1,
  parameter int NUM_EP      = 5,
  parameter int EP_BASE     = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              vbusValid,
  input  logic              otgId,
  input  logic              sofPulse,
  input  logic              busResetPulse,
  input  logic [NUM_EP-1:0] epAck,
  input  logic [NUM_EP-1:0] epStall,
  input  logic [NUM_EP-1:0] epTimeout,
  input  logic [NUM_EP-1:0] epInErr,
  input  logic [NUM_EP-1:0] epOutErr,
  input  logic [NUM_EP-1:0] epNak,
  input  logic [NUM_EP-1:0] epNakIntEn,
  input  logic [REG_W-1:0]  irqEn,
  input  logic              wrEn,
  input  logic [REG_W-1:0]  wrData,
  output flagStrobe_t       strobe
);

  localparam logic [REG_W-1:0] IMPL_MASK = implMask(IS_PRIMARY, EP_BASE, NUM_EP);
  localparam int ARM_CYC = SYNC_STAGES + 1;
  localparam int ARM_W   = $clog2(ARM_CYC + 1);

  logic [ARM_W-1:0]  armCnt;
  logic              armed;
  logic              vbusEdge;
  logic              idEdge;
  logic [NUM_EP-1:0] epHit;

  // hold the edge detectors quiet until their history is a real sample
  assign armed = (armCnt == ARM_W'(ARM_CYC));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)       armCnt <= '0;
    else if (!armed) armCnt <= armCnt + 1'b1;
  end

  generate
    if (IS_PRIMARY) begin : g_otg
      usb_intr_edge #(.SYNC_STAGES(SYNC_STAGES)) u_vbusEdge (
        .clk(clk), .rstN(rstN), .armed(armed),
        .asyncIn(vbusValid), .edgeSeen(vbusEdge));
      usb_intr_edge #(.SYNC_STAGES(SYNC_STAGES)) u_idEdge (
        .clk(clk), .rstN(rstN), .armed(armed),
        .asyncIn(otgId), .edgeSeen(idEdge));
    end else begin : g_noOtg
      logic unusedOtg;
      assign unusedOtg = vbusValid ^ otgId ^ armed;
      assign vbusEdge  = 1'b0;
      assign idEdge    = 1'b0;
    end
  endgenerate

  // each endpoint aggregates its outcomes; NAK only under its own enable
  generate
    for (genvar e = 0; e < NUM_EP; e++) begin : g_ep
      assign epHit[e] = epAck[e] | epStall[e] | epTimeout[e] |
                        epInErr[e] | epOutErr[e] |
                        (epNak[e] & epNakIntEn[e]);

      // R7
      nak_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
        (epNak[e] && !epNakIntEn[e] && !epAck[e] && !epStall[e] &&
         !epTimeout[e] && !epInErr[e] && !epOutErr[e])
        |-> !strobe.setMask[EP_BASE+e]);
    end
  endgenerate

  always_comb begin
    logic [REG_W-1:0] raw;
    raw = '0;
    raw[VBUS_BIT]   = vbusEdge;
    raw[ID_BIT]     = idEdge;
    raw[SOF_BIT]    = sofPulse;
    raw[BUSRST_BIT] = busResetPulse;
    for (int e = 0; e < NUM_EP; e++) raw[EP_BASE+e] = epHit[e];
    strobe.setMask = raw & irqEn & IMPL_MASK;
    strobe.clrMask = wrEn ? (wrData & IMPL_MASK) : '0;
  end

  // R10
  en_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.setMask & ~irqEn) == '0);

endmodule

// File: rtl/usb_intr_dpath.sv
module usb_intr_dpath
  import usb_intr_pkg::*;
#(
  parameter logic [REG_W-1:0] IMPL_MASK = '1
) (
  input  logic             clk,
  input  logic             rstN,
  input  flagStrobe_t      strobe,
  output logic [REG_W-1:0] statusRd,
  output logic             irqOut
);

  logic [REG_W-1:0] status;

  // sticky flags: clear first, then set, so a coincident event survives
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) status <= '0;
    else       status <= (status & ~strobe.clrMask) | strobe.setMask;
  end

  assign statusRd = status;
  assign irqOut   = |status;

  // R11
  unused_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (status & ~IMPL_MASK) == '0);

  // R9
  set_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((status & $past(strobe.setMask)) == $past(strobe.setMask)));

  // R8
  clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((status & $past(strobe.clrMask & ~strobe.setMask)) == '0));

  // R8
  hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (((status ^ $past(status)) &
               ~$past(strobe.setMask | strobe.clrMask)) == '0));

endmodule

// File: rtl/usb_intr_status.sv
module usb_intr_status
  import usb_intr_pkg::*;
#(
  parameter bit IS_PRIMARY  = 1'b1,
  parameter int NUM_EP      = 5,
  parameter int EP_BASE     = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              vbusValid,
  input  logic              otgId,
  input  logic              sofPulse,
  input  logic              busResetPulse,
  input  logic [NUM_EP-1:0] epAck,
  input  logic [NUM_EP-1:0] epStall,
  input  logic [NUM_EP-1:0] epTimeout,
  input  logic [NUM_EP-1:0] epInErr,
  input  logic [NUM_EP-1:0] epOutErr,
  input  logic [NUM_EP-1:0] epNak,
  input  logic [NUM_EP-1:0] epNakIntEn,
  input  logic [15:0]       irqEn,
  input  logic              wrEn,
  input  logic [15:0]       wrData,
  output logic [15:0]       statusRd,
  output logic              irqOut
);

  localparam logic [REG_W-1:0] IMPL_MASK = implMask(IS_PRIMARY, EP_BASE, NUM_EP);

  flagStrobe_t strobe;

  usb_intr_ctrl #(
    .IS_PRIMARY(IS_PRIMARY), .NUM_EP(NUM_EP),
    .EP_BASE(EP_BASE), .SYNC_STAGES(SYNC_STAGES)
  ) u_ctrl (
    .clk(clk), .rstN(rstN),
    .vbusValid(vbusValid), .otgId(otgId),
    .sofPulse(sofPulse), .busResetPulse(busResetPulse),
    .epAck(epAck), .epStall(epStall), .epTimeout(epTimeout),
    .epInErr(epInErr), .epOutErr(epOutErr),
    .epNak(epNak), .epNakIntEn(epNakIntEn),
    .irqEn(irqEn), .wrEn(wrEn), .wrData(wrData),
    .strobe(strobe)
  );

  usb_intr_dpath #(.IMPL_MASK(IMPL_MASK)) u_dpath (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .statusRd(statusRd), .irqOut(irqOut)
  );

endmodule

// File: tb/usb_intr_status_bench.sv
module usb_intr_status_bench;

  localparam int CLK_PERIOD = 10;
  localparam int NUM_EP     = 5;
  localparam logic [15:0] PRI_MASK = 16'hC3F8;
  localparam logic [15:0] SEC_MASK = 16'h03F8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic vbusValid = 1'b1, otgId = 1'b1;
  logic sofPulse = 1'b0, busResetPulse = 1'b0;
  logic [NUM_EP-1:0] epAck = '0, epStall = '0, epTimeout = '0;
  logic [NUM_EP-1:0] epInErr = '0, epOutErr = '0, epNak = '0, epNakIntEn = '0;
  logic [15:0] irqEn = '0;
  logic wrEn = 1'b0;
  logic [15:0] wrData = '0;
  logic [15:0] statusPri, statusSec;
  logic irqPri, irqSec;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  usb_intr_status #(.IS_PRIMARY(1'b1)) u_usb_intr_status (
    .clk(clk), .rstN(rstN), .vbusValid(vbusValid), .otgId(otgId),
    .sofPulse(sofPulse), .busResetPulse(busResetPulse),
    .epAck(epAck), .epStall(epStall), .epTimeout(epTimeout),
    .epInErr(epInErr), .epOutErr(epOutErr), .epNak(epNak),
    .epNakIntEn(epNakIntEn), .irqEn(irqEn), .wrEn(wrEn), .wrData(wrData),
    .statusRd(statusPri), .irqOut(irqPri));

  usb_intr_status #(.IS_PRIMARY(1'b0)) u_usb_intr_status_sec (
    .clk(clk), .rstN(rstN), .vbusValid(vbusValid), .otgId(otgId),
    .sofPulse(sofPulse), .busResetPulse(busResetPulse),
    .epAck(epAck), .epStall(epStall), .epTimeout(epTimeout),
    .epInErr(epInErr), .epOutErr(epOutErr), .epNak(epNak),
    .epNakIntEn(epNakIntEn), .irqEn(irqEn), .wrEn(wrEn), .wrData(wrData),
    .statusRd(statusSec), .irqOut(irqSec));

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // behavioural reference: pin samples kept in a short queue since reset
  logic [15:0] expPri = '0, expSec = '0;
  logic vq[$];
  logic iq[$];
  int seen = 0;

  always @(posedge clk) begin
    logic [15:0] setV, clrV;
    if (!rstN) begin
      expPri = '0; expSec = '0; seen = 0;
      vq.delete(); iq.delete();
    end else begin
      vq.push_back(vbusValid); iq.push_back(otgId);
      if (vq.size() > 4) begin void'(vq.pop_front()); void'(iq.pop_front()); end
      if (seen < 4) seen++;
      setV = '0;
      if (seen >= 4 && vq[1] != vq[0]) setV[15] = 1'b1;
      if (seen >= 4 && iq[1] != iq[0]) setV[14] = 1'b1;
      setV[9] = sofPulse;
      setV[8] = busResetPulse;
      for (int e = 0; e < NUM_EP; e++)
        setV[3+e] = epAck[e] | epStall[e] | epTimeout[e] | epInErr[e] |
                    epOutErr[e] | (epNak[e] & epNakIntEn[e]);
      setV &= irqEn;
      clrV = wrEn ? wrData : 16'h0;
      expPri = ((expPri & ~clrV) | setV) & PRI_MASK;
      expSec = ((expSec & ~clrV) | setV) & SEC_MASK;
    end
  end

  // per-cycle comparison against the model (R12 on the interrupt line)
  always @(negedge clk) begin
    if (!finished) begin
      check("model primary status", statusPri, expPri);
      check("model secondary status", statusSec, expSec);
      check("R12 primary irq", {15'b0, irqPri}, {15'b0, expPri != 0});
      check("R12 secondary irq", {15'b0, irqSec}, {15'b0, expSec != 0});
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic w1c(input logic [15:0] d);
    @(negedge clk); wrEn = 1'b1; wrData = d;
    @(negedge clk); wrEn = 1'b0; wrData = '0;
  endtask

  initial begin
    // R13: pins high through reset release
    tick(3);
    check("R1 reset status", statusPri, 16'h0);
    check("R1 reset irq", {15'b0, irqPri}, 16'h0);
    rstN = 1'b1;
    irqEn = 16'hFFFF;
    tick(10);
    check("R13 no startup flag", statusPri, 16'h0);

    // R2: falling then rising VBUS
    vbusValid = 1'b0; tick(4);
    check("R2 vbus fall", statusPri & 16'h8000, 16'h8000);
    check("R4 secondary otg bits", statusSec & 16'hC000, 16'h0);
    w1c(16'h8000);
    check("R8 clear vbus", statusPri, 16'h0);
    vbusValid = 1'b1; tick(4);
    check("R2 vbus rise", statusPri, 16'h8000);

    // R3
    otgId = 1'b0; tick(4);
    check("R3 id fall", statusPri, 16'hC000);
    check("R4 secondary after id", statusSec, 16'h0);
    w1c(16'h4000);
    check("R8 write zero keeps vbus", statusPri, 16'h8000);
    w1c(16'h8000);

    // R5
    @(negedge clk); sofPulse = 1'b1;
    @(negedge clk); sofPulse = 1'b0;
    check("R5 sof bit9", statusPri, 16'h0200);
    @(negedge clk); busResetPulse = 1'b1;
    @(negedge clk); busResetPulse = 1'b0;
    check("R5 bus reset bit8", statusPri, 16'h0300);
    w1c(16'hFFFF);
    check("R11 unused stay zero", statusPri, 16'h0);

    // R6: a different outcome on each endpoint
    @(negedge clk);
    epAck = 5'b00001; epStall = 5'b00010; epTimeout = 5'b00100;
    epInErr = 5'b01000; epOutErr = 5'b10000;
    @(negedge clk);
    epAck = '0; epStall = '0; epTimeout = '0; epInErr = '0; epOutErr = '0;
    check("R6 endpoint aggregate", statusPri, 16'h00F8);
    check("R6 secondary endpoints", statusSec, 16'h00F8);
    check("R11 unused after all set", statusPri & 16'h3C07, 16'h0);
    w1c(16'h00F8);

    // R7
    @(negedge clk); epNak = 5'b00100; epNakIntEn = 5'b00000;
    @(negedge clk); epNak = '0;
    check("R7 nak ignored when disabled", statusPri, 16'h0);
    @(negedge clk); epNak = 5'b00100; epNakIntEn = 5'b00100;
    @(negedge clk); epNak = '0;
    check("R7 nak counts when enabled", statusPri, 16'h0020);

    // R9: event and clear on bit 5 in the same cycle
    @(negedge clk); epNak = 5'b00100; wrEn = 1'b1; wrData = 16'h0020;
    @(negedge clk); epNak = '0; wrEn = 1'b0; wrData = '0;
    check("R9 set wins", statusPri, 16'h0020);
    w1c(16'h0020);

    // R10: disabled sources
    irqEn = 16'h0000;
    @(negedge clk); sofPulse = 1'b1; epAck = 5'b11111;
    @(negedge clk); sofPulse = 1'b0; epAck = '0;
    vbusValid = 1'b0; tick(6);
    check("R10 disabled no set", statusPri, 16'h0);
    irqEn = 16'hFFFF; tick(6);
    check("R10 old edge not latched", statusPri, 16'h0);
    check("R12 irq low when empty", {15'b0, irqPri}, 16'h0);

    tick(2);
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule